// File: doc/BRIEF.md
# Triple match-compare interval timer

A register-mapped peripheral holding three independent counters, each with a reload value and two compare values. Every counter can step on each system clock or on rising edges of an external tick. It counts either upward or downward. When it passes its end value it takes the reload value and flags an overflow. When its new value equals either compare value it flags a match.

Events are recorded in a sticky status register. A mask register and a per-timer overflow interrupt enable select which events reach that timer's interrupt line. Software programs it through a single-cycle read/write port. Typical uses are a periodic tick, built from an up-counter whose reload value sits P below the wrap point, and a one-shot event, built by setting a compare value a chosen distance ahead of the current count.

Top module: `tmr3`

## Requirements
- R1: Word registers, with byte address bits [1:0] = 0. Timer n (n = 0..2) sits at base 16*n, with the count at +0, the reload at +4, compare A at +8 and compare B at +12. Control is at 0x30, status at 0x34 and mask at 0x38. All of them read back what was written, within their widths (control 12 bits, status and mask 9 bits). Reset clears every register and every interrupt line to zero.
- R2: Control bits for timer n: bit 3n is run, bit 3n+1 is the clock source (0 = system clock, 1 = external tick) and bit 3n+2 is the overflow interrupt enable. Bit 9+n is the direction (1 = up, 0 = down).
- R3: A timer whose run bit is 0 keeps its count unchanged, and activity on another timer never alters it.
- R4: An up-counting timer on the system clock adds one per cycle. From all-ones it loads its reload value and sets status bit 3n+2. So count = reload = 2^32-P gives one overflow every P cycles.
- R5: A down-counting timer subtracts one per tick. From zero it loads its reload value and sets status bit 3n+2.
- R6: When a tick makes the new count equal to compare A, status bit 3n is set. When it equals compare B, status bit 3n+1 is set.
- R7: Status bits stay set until cleared. A write to the status register clears each bit written as 0 and leaves each bit written as 1 as it was.
- R8: irq[n] is high when an unmasked compare status bit of timer n is set, or when its overflow status bit is set, unmasked and enabled by bit 3n+2 of control. A mask bit of 1 blocks its event.
- R9: With clock source 1, the timer steps once per rising edge of ext_tick, after a two-flop synchronizer. A level held high steps it only once.
- R10: A bus write to a running timer's count takes effect in place of that cycle's tick, and counting resumes from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | Asynchronous external count source |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high with bus_sel |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | One interrupt line per timer |

## Verification
On every cycle, the bound assertions check several rules. An idle timer holds its count. A running up- or down-counter moves by exactly one. The wrap from the end value loads the reload value and raises the overflow flag. Status bits persist unless the status register is written. A fully masked timer keeps its interrupt low.

Some behaviour only the bench scenarios can show:
- compare hits landing on the right tick, including a hit on the reloaded value;
- the count of external edges after synchronization;
- a bus write to the count overriding a tick;
- control readback;
- every combination of mask and overflow enable on the interrupt line.

// File: rtl/tmr3.sv
module tmr3 #(
  parameter int CW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_tick,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [2:0]  irq
);
  localparam int NT = 3;
  localparam int EB = 3 * NT;
  localparam int CB = EB + NT;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [5:0] A_CTRL = 6'h30;
  localparam logic [5:0] A_STS  = 6'h34;
  localparam logic [5:0] A_MSK  = 6'h38;

  logic [CW-1:0] cnt_q  [NT];
  logic [CW-1:0] load_q [NT];
  logic [CW-1:0] m1_q   [NT];
  logic [CW-1:0] m2_q   [NT];
  logic [CW-1:0] nxt    [NT];
  logic [CB-1:0] ctrl_q;
  logic [EB-1:0] sts_q, msk_q, ev;
  logic [NT-1:0] hit, cwr, tick, wrap;
  logic [2:0]    sy_q;

  wire wr   = bus_sel & bus_we;
  wire rise = sy_q[1] & ~sy_q[2];

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      hit[t]  = wr && (bus_addr[5:4] == 2'(t)) && (bus_addr[1:0] == 2'b00);
      cwr[t]  = hit[t] && (bus_addr[3:2] == 2'd0);
      tick[t] = ctrl_q[3*t] && (ctrl_q[3*t+1] ? rise : 1'b1) && !cwr[t];
      wrap[t] = ctrl_q[EB+t] ? (cnt_q[t] == CMAX) : (cnt_q[t] == '0);
      nxt[t]  = wrap[t] ? load_q[t]
              : (ctrl_q[EB+t] ? cnt_q[t] + CW'(1) : cnt_q[t] - CW'(1));
      ev[3*t]   = tick[t] && (nxt[t] == m1_q[t]);
      ev[3*t+1] = tick[t] && (nxt[t] == m2_q[t]);
      ev[3*t+2] = tick[t] && wrap[t];
      irq[t] = |(sts_q[3*t +: 2] & ~msk_q[3*t +: 2])
             | (sts_q[3*t+2] & ~msk_q[3*t+2] & ctrl_q[3*t+2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy_q   <= '0;
      ctrl_q <= '0;
      sts_q  <= '0;
      msk_q  <= '0;
      for (int t = 0; t < NT; t++) begin
        cnt_q[t]  <= '0;
        load_q[t] <= '0;
        m1_q[t]   <= '0;
        m2_q[t]   <= '0;
      end
    end else begin
      sy_q <= {sy_q[1:0], ext_tick};
      if (wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[CB-1:0];
      if (wr && bus_addr == A_MSK)  msk_q  <= bus_wdata[EB-1:0];
      sts_q <= ((wr && bus_addr == A_STS) ? (sts_q & bus_wdata[EB-1:0]) : sts_q) | ev;
      for (int t = 0; t < NT; t++) begin
        if (cwr[t])       cnt_q[t] <= bus_wdata[CW-1:0];
        else if (tick[t]) cnt_q[t] <= nxt[t];
        if (hit[t] && bus_addr[3:2] == 2'd1) load_q[t] <= bus_wdata[CW-1:0];
        if (hit[t] && bus_addr[3:2] == 2'd2) m1_q[t]   <= bus_wdata[CW-1:0];
        if (hit[t] && bus_addr[3:2] == 2'd3) m2_q[t]   <= bus_wdata[CW-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr[5:4] != 2'd3) begin
        case (bus_addr[3:2])
          2'd0:    bus_rdata = 32'(cnt_q[bus_addr[5:4]]);
          2'd1:    bus_rdata = 32'(load_q[bus_addr[5:4]]);
          2'd2:    bus_rdata = 32'(m1_q[bus_addr[5:4]]);
          default: bus_rdata = 32'(m2_q[bus_addr[5:4]]);
        endcase
      end else begin
        case (bus_addr[3:2])
          2'd0:    bus_rdata = 32'(ctrl_q);
          2'd1:    bus_rdata = 32'(sts_q);
          2'd2:    bus_rdata = 32'(msk_q);
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

module tmr3_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [5:0]    bus_addr,
  input logic [11:0]   ctrl_q,
  input logic [8:0]    sts_q,
  input logic [8:0]    msk_q,
  input logic [2:0]    irq,
  input logic [CW-1:0] cnt_q  [3],
  input logic [CW-1:0] load_q [3]
);
  localparam logic [CW-1:0] CMAX = '1;
  wire wsts = bus_sel && bus_we && bus_addr == 6'h34;

  for (genvar b = 0; b < 9; b++) begin : g_bit
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[b] && !wsts) |=> sts_q[b]);
  end

  for (genvar t = 0; t < 3; t++) begin : g_tmr
    wire wc  = bus_sel && bus_we && bus_addr == 6'(16*t);
    wire run = ctrl_q[3*t] && !ctrl_q[3*t+1] && !wc;

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[3*t] && !wc) |=> $stable(cnt_q[t]));

    a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ctrl_q[9+t] && cnt_q[t] != CMAX) |=> cnt_q[t] == $past(cnt_q[t]) + CW'(1));

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ctrl_q[9+t] && cnt_q[t] == CMAX) |=> (cnt_q[t] == $past(load_q[t]) && sts_q[3*t+2]));

    a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ctrl_q[9+t] && cnt_q[t] != '0) |=> cnt_q[t] == $past(cnt_q[t]) - CW'(1));

    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (&msk_q[3*t +: 3]) |-> !irq[t]);
  end
endmodule

bind tmr3 tmr3_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .ctrl_q(ctrl_q), .sts_q(sts_q), .msk_q(msk_q), .irq(irq),
  .cnt_q(cnt_q), .load_q(load_q)
);

// File: tb/tmr3_test.sv
module tmr3_test;
  localparam int PER = 10;

  logic        clk = 0, rst_n = 0, ext_tick = 0, bus_sel = 0, bus_we = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire  [2:0]  irq;
  int nvec = 0, nbad = 0;
  logic [31:0] exp_cnt [3];

  always #(PER/2) clk = ~clk;

  tmr3 uut (.clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .bus_sel(bus_sel),
            .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
            .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] step(logic [31:0] v, logic up, logic [31:0] ld);
    if (up) return (v == 32'hFFFF_FFFF) ? ld : v + 32'd1;
    return (v == 32'd0) ? ld : v - 32'd1;
  endfunction

  task automatic run_case(int t, logic up, logic [31:0] st, logic [31:0] ld,
                          logic [31:0] m1, logic [31:0] m2, int k);
    logic [31:0] v, r;
    logic [2:0]  e;
    v = st; e = '0;
    wr(6'h30, 32'h0);
    wr(6'h34, 32'h0);
    wr(6'(16*t), st);
    wr(6'(16*t+4), ld);
    wr(6'(16*t+8), m1);
    wr(6'(16*t+12), m2);
    wr(6'h30, (32'h1 << (3*t)) | (32'(up) << (9+t)));
    repeat (k) @(negedge clk);
    wr(6'h30, 32'h0);
    for (int s = 0; s < k + 2; s++) begin
      if (up ? (v == 32'hFFFF_FFFF) : (v == 32'd0)) e[2] = 1'b1;
      v = step(v, up, ld);
      if (v == m1) e[0] = 1'b1;
      if (v == m2) e[1] = 1'b1;
    end
    exp_cnt[t] = v;
    for (int u = 0; u < 3; u++) begin
      rd(6'(16*u), r);
      if (u == t) chk(up ? "R4 up count/wrap" : "R5 down count/wrap", r, exp_cnt[u]);
      else        chk("R3 other timer holds", r, exp_cnt[u]);
    end
    rd(6'h34, r);
    chk("R6 status events", r, 32'(e) << (3*t));
    chk("R8 irq from matches", 32'(irq), 32'(e[0] | e[1]) << t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int ks [5] = '{0, 1, 2, 5, 9};
    logic [31:0] r;
    for (int i = 0; i < 3; i++) exp_cnt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int a = 0; a < 15; a++) begin
      rd(6'(4*a), r);
      chk("R1 reset value", r, 32'h0);
    end
    chk("R1 reset irq", 32'(irq), 32'h0);

    for (int t = 0; t < 3; t++)
      for (int q = 1; q < 4; q++) begin
        wr(6'(16*t+4*q), 32'hA5000000 + 32'(16*t+q));
        rd(6'(16*t+4*q), r);
        chk("R1 readback", r, 32'hA5000000 + 32'(16*t+q));
      end
    wr(6'h30, 32'hFFFF_FFB6);
    rd(6'h30, r);
    chk("R2 control readback", r, 32'h0000_0FB6);
    wr(6'h30, 32'h0);
    wr(6'h38, 32'hFFFF_FFFF);
    rd(6'h38, r);
    chk("R1 mask readback", r, 32'h1FF);
    wr(6'h38, 32'h0);

    for (int t = 0; t < 3; t++)
      for (int up = 0; up < 2; up++)
        for (int j = 0; j < 4; j++)
          foreach (ks[x]) begin
            logic [31:0] st, ld;
            st = (up != 0) ? 32'hFFFF_FFFF - 32'(j) : 32'(j);
            ld = 32'h100 + 32'(8*t + j);
            run_case(t, up[0], st, ld,
                     (up != 0) ? st + 32'd2 : st - 32'd2,
                     (up != 0) ? ld + 32'd1 : ld - 32'd1, ks[x]);
          end

    run_case(0, 1'b1, 32'hFFFF_FFFB, 32'hFFFF_FFFB, 32'hFFFF_FFFD, 32'h0, 12);

    wr(6'h20, 32'h0);
    wr(6'h30, 32'h840);
    repeat (3) @(negedge clk);
    wr(6'h20, 32'h1234);
    wr(6'h30, 32'h0);
    rd(6'h20, r);
    chk("R10 write beats tick", r, 32'h1236);
    exp_cnt[2] = 32'h1236;

    for (int n = 0; n < 7; n++) begin
      wr(6'h10, 32'd10);
      wr(6'h30, 32'h418);
      for (int p = 0; p < n; p++) begin
        @(negedge clk); ext_tick = 1;
        repeat (3) @(negedge clk);
        ext_tick = 0;
        repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      wr(6'h30, 32'h0);
      rd(6'h10, r);
      chk("R9 external edges counted", r, 32'd10 + 32'(n));
      exp_cnt[1] = 32'd10 + 32'(n);
    end

    run_case(0, 1'b1, 32'hFFFF_FFFE, 32'd5, 32'hFFFF_FFFF, 32'd6, 2);
    for (int ie = 0; ie < 2; ie++)
      for (int m = 0; m < 8; m++) begin
        logic ex;
        wr(6'h38, 32'(m));
        wr(6'h30, 32'(ie) << 2);
        ex = (m[0] == 1'b0) || (m[1] == 1'b0) || (m[2] == 1'b0 && ie != 0);
        chk("R8 mask and overflow enable", 32'(irq), 32'(ex));
      end
    wr(6'h38, 32'h0);
    wr(6'h30, 32'h0);

    for (int p = 0; p < 8; p++) begin
      run_case(0, 1'b1, 32'hFFFF_FFFE, 32'd5, 32'hFFFF_FFFF, 32'd6, 2);
      wr(6'h34, 32'h1F8 | 32'(p));
      rd(6'h34, r);
      chk("R7 write-zero clears, write-one keeps", r, 32'(p));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule